// File: doc/BRIEF.md
# Shared Interrupt Source Bank

The bank takes thirty-two asynchronous interrupt lines and turns each one into a pending bit. Each line has its own detection mode: level, single edge, or both edges. A polarity bit selects the active level, or the active edge in single-edge mode. Edge events are held in a sticky bit. Software can set or clear that sticky bit through a trigger register, which also lets software raise an interrupt that no wire drove.

A per-line enable mask is changed through separate write-one-to-set and write-one-to-clear registers, so software never needs a read-modify-write. Each line also has a map word that can route it to one of eight output pins, to a non-maskable output, or to both. The outputs are registered.

A plain 32-bit register port gives software access. It accepts a write or a read in every cycle and has no back-pressure. Read data appears on `bus_rdata` in the cycle after `bus_rd` is sampled high. The interrupt inputs and the routed outputs are plain level signals, not streams.

Top module: `shirq_bank`

## Requirements
- R1: After reset, all routing is off, every line is masked and the outputs are low. The following registers read as shown: mode (word address 0x00) reads 0, meaning level; polarity (0x01) reads all ones, meaning active-high; dual (0x02) reads 0; mask status (0x06) reads 0; each map word (0x20 + n) reads 0.
- R2: In level mode, pending bit n (read at 0x07) equals input n after two synchronizer flops when polarity bit n is 1, and equals its inverse when polarity bit n is 0.
- R3: In edge mode (mode bit n = 1) with dual bit n = 0, a rising input latches pending bit n when polarity bit n is 1, and a falling input latches it when polarity bit n is 0. The opposite edge has no effect.
- R4: In edge mode with dual bit n = 1, both edges latch pending bit n, whatever the polarity bit holds.
- R5: A latched edge-mode pending bit stays set after the input returns to its idle level. It is cleared only by a write to the trigger register (0x03) with bit 31 = 0 and bits 7:0 = n.
- R6: A trigger-register write with bit 31 = 1 sets pending bit n of an edge-mode line. Numbers 32 and above in bits 7:0 change nothing. In level mode, pending follows only the input, so a trigger write has no effect.
- R7: Writing 1 to bit n of the mask-set register (0x05) enables line n. Zero bits leave their enables unchanged.
- R8: Writing 1 to bit n of the mask-clear register (0x04) disables line n. Zero bits leave their enables unchanged.
- R9: Map word n holds three fields: bit 31 routes the line to a pin, bit 30 routes it to the non-maskable output, and bits 5:0 select the pin. Output pin p is high one cycle after any line routed to p is both pending and enabled. While every line is masked, no pin is high.
- R10: A pin number of 8 or more drives no pin.
- R11: The non-maskable output is high one cycle after any line with map bit 30 set is pending, whatever the mask holds.
- R12: The trigger, mask-clear and mask-set registers are write-only and read as 0. Read data is valid in the cycle after `bus_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_rd |
| irq_in | input | 32 | Raw asynchronous interrupt lines |
| irq_pin | output | 8 | Routed maskable output pins |
| irq_nmi | output | 1 | Routed non-maskable output |

## Verification
The hardest behaviour to reach from the ports is an edge that must not latch. Examples are the trailing edge in single-edge mode, or an edge that arrives after a soft clear while the input is still active. To reach these cases, the stimulus first latches a line, then clears it by software while the input is held, and only then drives the opposite transition. Pending is read back after each step. Routing cases drive one source line into a sticky state and then rewrite its map word and mask underneath it, so the pins, the non-maskable output and out-of-range pin numbers are all observed on the same pending bit.

// File: rtl/shirq_pkg.sv
package shirq_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 6;
  localparam int PIN_W    = 6;
  localparam int NUM_W    = 8;

  localparam logic [ADDR_W-1:0] A_MODE  = 6'h00;
  localparam logic [ADDR_W-1:0] A_POL   = 6'h01;
  localparam logic [ADDR_W-1:0] A_DUAL  = 6'h02;
  localparam logic [ADDR_W-1:0] A_SOFT  = 6'h03;
  localparam logic [ADDR_W-1:0] A_MCLR  = 6'h04;
  localparam logic [ADDR_W-1:0] A_MSET  = 6'h05;
  localparam logic [ADDR_W-1:0] A_MASK  = 6'h06;
  localparam logic [ADDR_W-1:0] A_PEND  = 6'h07;
  localparam int                MAP_BASE = 32;

  localparam int SOFT_SET_BIT = 31;
  localparam int MAP_PIN_BIT  = 31;
  localparam int MAP_NMI_BIT  = 30;
endpackage

// File: rtl/shirq_src.sv
module shirq_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  input  logic mode_edge,
  input  logic pol_high,
  input  logic dual_edge,
  input  logic sw_set,
  input  logic sw_clr,
  output logic pending
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic last_q;
  logic sticky_q;
  logic cur, rise, fall, evt;

  assign cur  = sync_q[SYNC_STAGES-1];
  assign rise = cur & ~last_q;
  assign fall = ~cur & last_q;

  always_comb begin
    if (dual_edge)     evt = rise | fall;
    else if (pol_high) evt = rise;
    else               evt = fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      last_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
      last_q <= cur;
      // a fresh edge wins over a simultaneous software clear
      if (!mode_edge)          sticky_q <= 1'b0;
      else if (evt || sw_set)  sticky_q <= 1'b1;
      else if (sw_clr)         sticky_q <= 1'b0;
    end
  end

  assign pending = mode_edge ? sticky_q : (pol_high ? cur : ~cur);
endmodule

// File: rtl/shirq_route.sv
module shirq_route #(
  parameter int NUM_SRC = 32,
  parameter int NUM_PIN = 8,
  parameter int PIN_W   = 6
) (
  input  logic [NUM_SRC-1:0]            active,
  input  logic [NUM_SRC-1:0]            pin_en,
  input  logic [NUM_SRC-1:0][PIN_W-1:0] pin_sel,
  input  logic [NUM_SRC-1:0]            nmi_src,
  output logic [NUM_PIN-1:0]            pin_hit,
  output logic                          nmi_hit
);
  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    always_comb begin
      pin_hit[p] = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (active[i] && pin_en[i] && (pin_sel[i] == PIN_W'(p)))
          pin_hit[p] = 1'b1;
      end
    end
  end

  assign nmi_hit = |nmi_src;
endmodule

// File: rtl/shirq_bank.sv
module shirq_bank
  import shirq_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int NUM_PIN     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_SRC-1:0]   irq_in,
  output logic [NUM_PIN-1:0]   irq_pin,
  output logic                 irq_nmi
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0]            mode_q, pol_q, dual_q, mask_q;
  logic [NUM_SRC-1:0]            pin_en_q, nmi_en_q;
  logic [NUM_SRC-1:0][PIN_W-1:0] pin_sel_q;
  logic [NUM_SRC-1:0]            pend_w, sw_set, sw_clr;
  logic [NUM_PIN-1:0]            pin_hit;
  logic                          nmi_hit;
  logic                          soft_wr, map_hit;
  logic [IDX_W-1:0]              map_idx;
  logic [NUM_W-1:0]              sw_num;
  logic [DATA_W-1:0]             rd_mux;

  assign soft_wr = bus_wr && (bus_addr == A_SOFT);
  assign sw_num  = bus_wdata[NUM_W-1:0];
  assign map_hit = (int'(bus_addr) >= MAP_BASE) && (int'(bus_addr) < MAP_BASE + NUM_SRC);
  assign map_idx = IDX_W'(bus_addr - ADDR_W'(MAP_BASE));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign sw_set[i] = soft_wr &&  bus_wdata[SOFT_SET_BIT] && (sw_num == NUM_W'(i));
    assign sw_clr[i] = soft_wr && !bus_wdata[SOFT_SET_BIT] && (sw_num == NUM_W'(i));
    shirq_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_in    (irq_in[i]),
      .mode_edge (mode_q[i]),
      .pol_high  (pol_q[i]),
      .dual_edge (dual_q[i]),
      .sw_set    (sw_set[i]),
      .sw_clr    (sw_clr[i]),
      .pending   (pend_w[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      pol_q     <= '1;
      dual_q    <= '0;
      mask_q    <= '0;
      pin_en_q  <= '0;
      nmi_en_q  <= '0;
      pin_sel_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE: mode_q <= bus_wdata[NUM_SRC-1:0];
        A_POL:  pol_q  <= bus_wdata[NUM_SRC-1:0];
        A_DUAL: dual_q <= bus_wdata[NUM_SRC-1:0];
        A_MCLR: mask_q <= mask_q & ~bus_wdata[NUM_SRC-1:0];
        A_MSET: mask_q <= mask_q |  bus_wdata[NUM_SRC-1:0];
        default: begin
          if (map_hit) begin
            pin_en_q[map_idx]  <= bus_wdata[MAP_PIN_BIT];
            nmi_en_q[map_idx]  <= bus_wdata[MAP_NMI_BIT];
            pin_sel_q[map_idx] <= bus_wdata[PIN_W-1:0];
          end
        end
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_MODE: rd_mux[NUM_SRC-1:0] = mode_q;
      A_POL:  rd_mux[NUM_SRC-1:0] = pol_q;
      A_DUAL: rd_mux[NUM_SRC-1:0] = dual_q;
      A_MASK: rd_mux[NUM_SRC-1:0] = mask_q;
      A_PEND: rd_mux[NUM_SRC-1:0] = pend_w;
      default: begin
        if (map_hit) begin
          rd_mux[MAP_PIN_BIT] = pin_en_q[map_idx];
          rd_mux[MAP_NMI_BIT] = nmi_en_q[map_idx];
          rd_mux[PIN_W-1:0]   = pin_sel_q[map_idx];
        end
      end
    endcase
  end

  shirq_route #(.NUM_SRC(NUM_SRC), .NUM_PIN(NUM_PIN), .PIN_W(PIN_W)) u_route (
    .active  (pend_w & mask_q),
    .pin_en  (pin_en_q),
    .pin_sel (pin_sel_q),
    .nmi_src (pend_w & nmi_en_q),
    .pin_hit (pin_hit),
    .nmi_hit (nmi_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      irq_pin   <= '0;
      irq_nmi   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_pin <= pin_hit;
      irq_nmi <= nmi_hit;
    end
  end
endmodule

// File: rtl/shirq_bank_chk.sv
module shirq_bank_chk
  import shirq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_PIN = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_wr,
  input logic                bus_rd,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PIN-1:0]  irq_pin,
  input logic [NUM_SRC-1:0]  mask_q,
  input logic [NUM_SRC-1:0]  mode_q,
  input logic [NUM_SRC-1:0]  pend_w
);
  logic clr_wr;
  assign clr_wr = bus_wr && (bus_addr == A_SOFT) && !bus_wdata[SOFT_SET_BIT];

  a_r7_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MSET) |=>
      ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == $past(bus_wdata[NUM_SRC-1:0])));

  a_r8_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MCLR) |=>
      ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

  a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> (irq_pin == '0));

  a_r5_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(clr_wr) && $stable(mode_q)) |->
      (((pend_w & mode_q) & $past(pend_w & mode_q)) == $past(pend_w & mode_q)));

  a_r12_wo_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == A_SOFT || bus_addr == A_MCLR || bus_addr == A_MSET))
      |=> (bus_rdata == '0));
endmodule

bind shirq_bank shirq_bank_chk #(.NUM_SRC(NUM_SRC), .NUM_PIN(NUM_PIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_pin   (irq_pin),
  .mask_q    (mask_q),
  .mode_q    (mode_q),
  .pend_w    (pend_w)
);

// File: tb/tb_shirq_bank.sv
`timescale 1ns/1ps
module tb_shirq_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic [7:0]  irq_pin;
  logic        irq_nmi;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] mode_v = '0;
  logic [31:0] pol_v = '1;
  logic [31:0] dual_v = '0;

  always #4 clk = ~clk;

  shirq_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_pin(irq_pin), .irq_nmi(irq_nmi)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(6'h00, v); chk("R1 mode reset", v, 32'h0);
    rd(6'h01, v); chk("R1 polarity reset", v, 32'hFFFF_FFFF);
    rd(6'h02, v); chk("R1 dual reset", v, 32'h0);
    rd(6'h06, v); chk("R1 mask reset", v, 32'h0);
    rd(6'h07, v); chk("R1 pending reset", v, 32'h0);
    rd(6'h20, v); chk("R1 map0 reset", v, 32'h0);
    rd(6'h3F, v); chk("R1 map31 reset", v, 32'h0);
    chk("R1 pins reset", {24'h0, irq_pin}, 32'h0);
    chk("R1 nmi reset", {31'h0, irq_nmi}, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    irq_in[3] = 1'b1; settle();
    rd(6'h07, v); chk("R2 level high active", v, 32'h0000_0008);
    pol_v[3] = 1'b0; wr(6'h01, pol_v); settle();
    rd(6'h07, v); chk("R2 level low, input high", v, 32'h0);
    irq_in[3] = 1'b0; settle();
    rd(6'h07, v); chk("R2 level low, input low", v, 32'h0000_0008);
    pol_v[3] = 1'b1; wr(6'h01, pol_v); settle();
    rd(6'h07, v); chk("R2 restored idle", v, 32'h0);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    mode_v[5] = 1'b1; wr(6'h00, mode_v);
    irq_in[5] = 1'b1; settle();
    rd(6'h07, v); chk("R3 rising latches", v, 32'h0000_0020);
    irq_in[5] = 1'b0; settle();
    rd(6'h07, v); chk("R5 sticky after input idle", v, 32'h0000_0020);
    wr(6'h03, 32'h0000_0005); settle();
    rd(6'h07, v); chk("R5 soft clear", v, 32'h0);
    irq_in[5] = 1'b1; settle();
    wr(6'h03, 32'h0000_0005); settle();
    irq_in[5] = 1'b0; settle();
    rd(6'h07, v); chk("R3 falling ignored when rising", v, 32'h0);
    pol_v[5] = 1'b0; wr(6'h01, pol_v);
    irq_in[5] = 1'b1; settle();
    rd(6'h07, v); chk("R3 rising ignored when falling", v, 32'h0);
    irq_in[5] = 1'b0; settle();
    rd(6'h07, v); chk("R3 falling latches", v, 32'h0000_0020);
    wr(6'h03, 32'h0000_0005); settle();
  endtask

  task automatic t_dual();
    logic [31:0] v;
    mode_v[7] = 1'b1; wr(6'h00, mode_v);
    dual_v[7] = 1'b1; wr(6'h02, dual_v);
    pol_v[7] = 1'b1; wr(6'h01, pol_v);
    irq_in[7] = 1'b1; settle();
    rd(6'h07, v); chk("R4 dual rising", v, 32'h0000_0080);
    wr(6'h03, 32'h0000_0007); settle();
    rd(6'h07, v); chk("R4 cleared while high", v, 32'h0);
    irq_in[7] = 1'b0; settle();
    rd(6'h07, v); chk("R4 dual falling", v, 32'h0000_0080);
    wr(6'h03, 32'h0000_0007); settle();
  endtask

  task automatic t_soft();
    logic [31:0] v;
    mode_v[9] = 1'b1; wr(6'h00, mode_v);
    wr(6'h03, 32'h8000_0009); settle();
    rd(6'h07, v); chk("R6 soft set", v, 32'h0000_0200);
    wr(6'h03, 32'h8000_0029); settle();
    rd(6'h07, v); chk("R6 number out of range", v, 32'h0000_0200);
    wr(6'h03, 32'h8000_000A); settle();
    rd(6'h07, v); chk("R6 level line unaffected", v, 32'h0000_0200);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(6'h05, 32'h0000_00F0); rd(6'h06, v); chk("R7 mask set", v, 32'h0000_00F0);
    wr(6'h05, 32'h0); rd(6'h06, v); chk("R7 zero no effect", v, 32'h0000_00F0);
    wr(6'h04, 32'h0000_0030); rd(6'h06, v); chk("R8 mask clear", v, 32'h0000_00C0);
    wr(6'h04, 32'h0); rd(6'h06, v); chk("R8 zero no effect", v, 32'h0000_00C0);
    wr(6'h04, 32'hFFFF_FFFF); rd(6'h06, v); chk("R8 clear all", v, 32'h0);
  endtask

  task automatic t_route();
    logic [31:0] v;
    wr(6'h29, 32'h8000_0002); settle();
    rd(6'h29, v); chk("R9 map readback", v, 32'h8000_0002);
    chk("R9 masked pin low", {24'h0, irq_pin}, 32'h0);
    wr(6'h05, 32'h0000_0200); settle();
    chk("R9 pin 2 asserted", {24'h0, irq_pin}, 32'h0000_0004);
    chk("R9 nmi quiet", {31'h0, irq_nmi}, 32'h0);
    wr(6'h29, 32'h8000_000A); settle();
    chk("R10 pin 10 ignored", {24'h0, irq_pin}, 32'h0);
    wr(6'h29, 32'h4000_0000); wr(6'h04, 32'h0000_0200); settle();
    chk("R11 nmi despite mask", {31'h0, irq_nmi}, 32'h1);
    wr(6'h03, 32'h0000_0009); settle();
    chk("R11 nmi drops", {31'h0, irq_nmi}, 32'h0);
  endtask

  task automatic t_wo();
    logic [31:0] v;
    rd(6'h03, v); chk("R12 trigger reads 0", v, 32'h0);
    rd(6'h04, v); chk("R12 mask clear reads 0", v, 32'h0);
    rd(6'h05, v); chk("R12 mask set reads 0", v, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_level();
    t_edge();
    t_dual();
    t_soft();
    t_mask();
    t_route();
    t_wo();
    finish_run();
  end

  initial begin
    #1_600_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule